// File: doc/BRIEF.md
# Arrival histogram logger

This block sits beside one receive port and watches a single-cycle arrival strobe that carries a packet sequence number. Every accepted arrival is counted, is written into a bounded event log as a timestamp plus the sequence number, and, from the second arrival on, adds one to a histogram bin chosen by the time since the previous arrival. Time comes from a free-running counter that advances once per clock, so at 200 MHz one tick is 5 ns.

Control is a level `ctl_arm` that enables capture and a one-cycle `ctl_clr` that restarts a measurement. A clear zeroes the counters and the log, and sweeps the histogram memory to zero at one bin per cycle while `busy` is high. Software reads histogram bins and log fields through a small synchronous read port with one cycle of latency. The packet and log counters are exposed directly.

Top module: `arrival_histogram_logger`

## Requirements
- R1: Reset zeroes `pkt_count` and `log_count`, clears `log_full`, and starts a sweep that holds `busy` high for exactly NBINS cycles and leaves every histogram bin at zero.
- R2: An arrival is accepted when `pkt_valid` is high while `ctl_arm` is high, `busy` is low and `ctl_clr` is low. Each accepted arrival raises `pkt_count` by one on the following cycle.
- R3: The interval is the difference between the tick counts at two successive accepted arrivals. The bin index is the interval shifted right by `cfg_shift`, and any index above NBINS-1 is clamped to NBINS-1. That bin gains one count.
- R4: The first accepted arrival after reset, after a clear, or after `ctl_arm` has been low makes no histogram entry.
- R5: Arrivals on consecutive cycles that map to the same bin are each counted, so N back-to-back arrivals with `cfg_shift`=0 give N-1 counts in bin 1.
- R6: A histogram bin holds at 2^CNT_W-1 and does not wrap.
- R7: Each accepted arrival, while the log has room, is stored at log index `log_count`. The stored entry holds the tick count at the arrival and `pkt_seq`.
- R8: After LOG_DEPTH entries the log stops writing, `log_full` goes high and `log_count` stays at LOG_DEPTH. Packet counting and histogram updates continue.
- R9: A `ctl_clr` pulse zeroes `pkt_count`, `log_count` and `log_full`, and starts the NBINS-cycle sweep. Arrivals while `busy` is high are ignored, and only a clear raises `busy`.
- R10: Arrivals while `ctl_arm` is low are ignored.
- R11: A read with `rd_en` high returns data on `rd_data` on the next cycle. The field is chosen by `rd_sel`: 0 gives histogram bin `rd_addr`, 1 gives the timestamp of log entry `rd_addr`, 2 gives its sequence number, and 3 gives zero. Narrower values are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Arrival strobe, one cycle per packet |
| pkt_seq | input | SEQ_W | Sequence number of the arriving packet |
| ctl_arm | input | 1 | Capture enable (level) |
| ctl_clr | input | 1 | Clear pulse: restarts counters, log and histogram |
| cfg_shift | input | SH_W | Right shift applied to the interval to form the bin index |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Read field: 0 bin, 1 log timestamp, 2 log sequence, 3 zero |
| rd_addr | input | ADDR_W | Bin index or log index |
| rd_data | output | 32 | Read result, valid the cycle after `rd_en` |
| busy | output | 1 | Histogram sweep in progress |
| log_full | output | 1 | Log holds LOG_DEPTH entries |
| pkt_count | output | PKT_W | Accepted arrivals since the last clear |
| log_count | output | LB_W+1 | Entries stored in the log |

## Verification
The critical collision is the histogram read-modify-write. An arrival's bin is read in one cycle and written in the next, so when two arrivals one cycle apart hit the same bin, the read for the second one lands in the same cycle as the write for the first. Bursts of strobes on consecutive cycles, and also two cycles apart, provoke this. The bench judges it by the exact count left in the bin: any lost increment shows up as a short count. A second overlap, a clear arriving while capture is armed and strobes keep coming, is judged by the counters and the histogram reading zero after the sweep.

// File: rtl/ahl_pkg.sv
package ahl_pkg;
    // Field selector of the readback port.
    typedef enum logic [1:0] {
        SEL_HIST = 2'd0,
        SEL_TS   = 2'd1,
        SEL_SEQ  = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/ahl_ram.sv
// Storage array with one write port and NRD synchronous read ports.
// A read of the address being written returns the old content.
module ahl_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [NRD-1:0]            ren,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NRD; p++) begin
            if (ren[p]) begin
                rdata[p] <= mem[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/ahl_bin_map.sv
// Maps an interval in ticks to a histogram bin: scale by a right shift,
// clamp to the last bin.
module ahl_bin_map #(
    parameter int IVL_W = 32,
    parameter int NBINS = 64,
    parameter int SH_W  = 5,
    localparam int BW   = $clog2(NBINS)
) (
    input  logic [IVL_W-1:0] interval,
    input  logic [SH_W-1:0]  shift,
    output logic [BW-1:0]    bin
);
    logic [IVL_W-1:0] scaled;

    always_comb begin
        scaled = interval >> shift;
        if (scaled > IVL_W'(NBINS - 1)) begin
            bin = BW'(NBINS - 1);
        end else begin
            bin = scaled[BW-1:0];
        end
    end
endmodule

// File: rtl/arrival_histogram_logger.sv
module arrival_histogram_logger
    import ahl_pkg::*;
#(
    parameter int TS_W      = 32,
    parameter int SEQ_W     = 16,
    parameter int NBINS     = 64,
    parameter int CNT_W     = 32,
    parameter int LOG_DEPTH = 2048,
    parameter int PKT_W     = 32,
    parameter int SH_W      = 5,
    localparam int HB_W     = $clog2(NBINS),
    localparam int LB_W     = $clog2(LOG_DEPTH),
    localparam int LC_W     = LB_W + 1,
    localparam int ADDR_W   = (HB_W > LB_W) ? HB_W : LB_W,
    localparam int DATA_W   = 32,
    localparam int LOG_W    = TS_W + SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [SEQ_W-1:0]  pkt_seq,
    input  logic              ctl_arm,
    input  logic              ctl_clr,
    input  logic [SH_W-1:0]   cfg_shift,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              log_full,
    output logic [PKT_W-1:0]  pkt_count,
    output logic [LC_W-1:0]   log_count
);
    typedef struct packed {
        logic [TS_W-1:0]  ts;        // free-running tick counter
        logic [TS_W-1:0]  last_ts;   // tick of previous accepted arrival
        logic             have_prev;
        logic [PKT_W-1:0] pkt_cnt;
        logic [LC_W-1:0]  log_cnt;
        logic             busy;
        logic [HB_W-1:0]  sweep;
        logic             s1_v;      // bin read issued this cycle
        logic [HB_W-1:0]  s1_bin;
        logic             s2_v;      // bin written this cycle
        logic [HB_W-1:0]  s2_bin;
        logic             fwd_v;     // s2 must use fwd_val instead of RAM data
        logic [CNT_W-1:0] fwd_val;
        logic [1:0]       rsel;
        logic             roor;      // readback address out of range
    } state_t;

    state_t q, d;

    logic              accept;
    logic              log_room;
    logic [TS_W-1:0]   interval;
    logic [HB_W-1:0]   cur_bin;
    logic [CNT_W-1:0]  old_cnt;
    logic [CNT_W-1:0]  upd_cnt;

    logic                        h_we;
    logic [HB_W-1:0]             h_waddr;
    logic [CNT_W-1:0]            h_wdata;
    logic [1:0]                  h_ren;
    logic [1:0][HB_W-1:0]        h_raddr;
    logic [1:0][CNT_W-1:0]       h_rdata;

    logic                        l_we;
    logic [0:0]                  l_ren;
    logic [0:0][LB_W-1:0]        l_raddr;
    logic [0:0][LOG_W-1:0]       l_rdata;

    ahl_bin_map #(
        .IVL_W (TS_W),
        .NBINS (NBINS),
        .SH_W  (SH_W)
    ) bin_map_i (
        .interval (interval),
        .shift    (cfg_shift),
        .bin      (cur_bin)
    );

    // Port 0 serves the update pipeline, port 1 the readback.
    ahl_ram #(
        .DEPTH (NBINS),
        .WIDTH (CNT_W),
        .NRD   (2)
    ) hist_ram_i (
        .clk   (clk),
        .we    (h_we),
        .waddr (h_waddr),
        .wdata (h_wdata),
        .ren   (h_ren),
        .raddr (h_raddr),
        .rdata (h_rdata)
    );

    ahl_ram #(
        .DEPTH (LOG_DEPTH),
        .WIDTH (LOG_W),
        .NRD   (1)
    ) log_ram_i (
        .clk   (clk),
        .we    (l_we),
        .waddr (q.log_cnt[LB_W-1:0]),
        .wdata ({q.ts, pkt_seq}),
        .ren   (l_ren),
        .raddr (l_raddr),
        .rdata (l_rdata)
    );

    always_comb begin
        accept   = pkt_valid && ctl_arm && !q.busy && !ctl_clr;
        log_room = q.log_cnt < LC_W'(LOG_DEPTH);
        interval = q.ts - q.last_ts;

        // Stage 2: increment the bin value, forwarded if the previous
        // write hit the same bin while this one was being read.
        old_cnt = q.fwd_v ? q.fwd_val : h_rdata[0];
        upd_cnt = (&old_cnt) ? old_cnt : old_cnt + CNT_W'(1);

        h_we    = q.busy || q.s2_v;
        h_waddr = q.busy ? q.sweep : q.s2_bin;
        h_wdata = q.busy ? '0 : upd_cnt;
        h_ren   = {rd_en && (rd_sel == SEL_HIST), 1'b1};
        h_raddr = {rd_addr[HB_W-1:0], q.s1_bin};

        l_we       = accept && log_room;
        l_ren[0]   = rd_en;
        l_raddr[0] = rd_addr[LB_W-1:0];

        d = q;
        d.ts = q.ts + TS_W'(1);

        d.fwd_v   = q.s1_v && q.s2_v && (q.s1_bin == q.s2_bin);
        d.fwd_val = upd_cnt;
        d.s2_v    = q.s1_v;
        d.s2_bin  = q.s1_bin;
        d.s1_v    = accept && q.have_prev;
        d.s1_bin  = cur_bin;

        if (accept) begin
            d.pkt_cnt   = q.pkt_cnt + PKT_W'(1);
            d.last_ts   = q.ts;
            d.have_prev = 1'b1;
            if (log_room) begin
                d.log_cnt = q.log_cnt + LC_W'(1);
            end
        end
        if (!ctl_arm) begin
            d.have_prev = 1'b0;
        end

        if (q.busy) begin
            d.sweep = q.sweep + HB_W'(1);
            if (q.sweep == HB_W'(NBINS - 1)) begin
                d.busy = 1'b0;
            end
        end

        if (ctl_clr) begin
            d.busy      = 1'b1;
            d.sweep     = '0;
            d.pkt_cnt   = '0;
            d.log_cnt   = '0;
            d.have_prev = 1'b0;
            d.s1_v      = 1'b0;
            d.s2_v      = 1'b0;
            d.fwd_v     = 1'b0;
        end

        if (rd_en) begin
            d.rsel = rd_sel;
            if (rd_sel == SEL_HIST) begin
                d.roor = {1'b0, rd_addr} >= (ADDR_W + 1)'(NBINS);
            end else begin
                d.roor = {1'b0, rd_addr} >= (ADDR_W + 1)'(LOG_DEPTH);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.busy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (!q.roor) begin
            case (rd_sel_e'(q.rsel))
                SEL_HIST: rd_data = DATA_W'(h_rdata[1]);
                SEL_TS:   rd_data = DATA_W'(l_rdata[0][SEQ_W +: TS_W]);
                SEL_SEQ:  rd_data = DATA_W'(l_rdata[0][SEQ_W-1:0]);
                default:  rd_data = '0;
            endcase
        end
    end

    assign busy      = q.busy;
    assign log_full  = (q.log_cnt == LC_W'(LOG_DEPTH));
    assign pkt_count = q.pkt_cnt;
    assign log_count = q.log_cnt;
endmodule

// File: rtl/ahl_checker.sv
module ahl_checker #(
    parameter int PKT_W     = 32,
    parameter int LC_W      = 12,
    parameter int LOG_DEPTH = 2048
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic             ctl_arm,
    input logic             ctl_clr,
    input logic             busy,
    input logic             log_full,
    input logic [PKT_W-1:0] pkt_count,
    input logic [LC_W-1:0]  log_count
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && ctl_arm && !busy && !ctl_clr)
        |=> (pkt_count == PKT_W'($past(pkt_count) + PKT_W'(1))));

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_clr) |=> ($stable(pkt_count) && $stable(log_count)));

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr |=> (pkt_count == '0 && log_count == '0 && busy));

    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_clr));

    assert_arm_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_arm && !ctl_clr) |=> $stable(pkt_count));

    assert_log_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (log_full && !ctl_clr) |=> ($stable(log_count) && log_full));

    assert_log_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        log_count <= LC_W'(LOG_DEPTH));
endmodule

bind arrival_histogram_logger ahl_checker #(
    .PKT_W     (PKT_W),
    .LC_W      (LC_W),
    .LOG_DEPTH (LOG_DEPTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_valid (pkt_valid),
    .ctl_arm   (ctl_arm),
    .ctl_clr   (ctl_clr),
    .busy      (busy),
    .log_full  (log_full),
    .pkt_count (pkt_count),
    .log_count (log_count)
);

// File: tb/arrival_histogram_logger_tb_top.sv
`timescale 1ns/1ps
module arrival_histogram_logger_tb_top;
    localparam int NB  = 16;
    localparam int CW  = 5;
    localparam int LD  = 16;
    localparam int SQW = 16;
    localparam int AW  = 4;
    localparam int LCW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pkt_valid = 1'b0;
    logic [SQW-1:0]  pkt_seq = '0;
    logic            ctl_arm = 1'b0;
    logic            ctl_clr = 1'b0;
    logic [4:0]      cfg_shift = '0;
    logic            rd_en = 1'b0;
    logic [1:0]      rd_sel = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [31:0]     rd_data;
    logic            busy;
    logic            log_full;
    logic [31:0]     pkt_count;
    logic [LCW-1:0]  log_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    arrival_histogram_logger #(
        .TS_W(32), .SEQ_W(SQW), .NBINS(NB), .CNT_W(CW),
        .LOG_DEPTH(LD), .PKT_W(32), .SH_W(5)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_seq(pkt_seq),
        .ctl_arm(ctl_arm), .ctl_clr(ctl_clr), .cfg_shift(cfg_shift),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .log_full(log_full), .pkt_count(pkt_count),
        .log_count(log_count)
    );

    // Stimulus table: gap in ticks, shift, expected bin.
    localparam int VEC_N = 8;
    localparam logic [23:0] VEC [VEC_N] = '{
        {8'd3,   8'd0, 8'd3},
        {8'd1,   8'd0, 8'd1},
        {8'd7,   8'd1, 8'd3},
        {8'd40,  8'd2, 8'd10},
        {8'd63,  8'd2, 8'd15},
        {8'd64,  8'd2, 8'd15},
        {8'd200, 8'd0, 8'd15},
        {8'd20,  8'd4, 8'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, input int addr, output logic [31:0] v);
        rd_en   = 1'b1;
        rd_sel  = sel;
        rd_addr = AW'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic hist_sum(output int s);
        logic [31:0] v;
        s = 0;
        for (int b = 0; b < NB; b++) begin
            rd(2'd0, b, v);
            s += int'(v);
        end
    endtask

    task automatic send(input int seq);
        pkt_valid = 1'b1;
        pkt_seq   = SQW'(seq);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic clear_all();
        ctl_clr = 1'b1;
        @(negedge clk);
        ctl_clr = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] t0;
        logic [31:0] t1;
        int s;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and sweep length
        chk("R1 busy", 32'(busy), 1);
        chk("R1 pkt_count", pkt_count, 0);
        chk("R1 log_count", 32'(log_count), 0);
        chk("R1 log_full", 32'(log_full), 0);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk("R1 sweep cycles", 32'(n), NB);
        hist_sum(s);
        chk("R1 hist zero", 32'(s), 0);

        // Table: R2 counting, R3 binning
        for (int i = 0; i < VEC_N; i++) begin
            int gap;
            int expb;
            gap  = int'(VEC[i][23:16]);
            expb = int'(VEC[i][7:0]);
            ctl_arm = 1'b0;
            clear_all();
            cfg_shift = VEC[i][12:8];
            ctl_arm = 1'b1;
            send(10);
            repeat (gap - 1) @(negedge clk);
            send(11);
            drain();
            chk("R2 pkt_count", pkt_count, 2);
            rd(2'd0, expb, v);
            chk("R3 bin count", v, 1);
            hist_sum(s);
            chk("R3 hist total", 32'(s), 1);
        end

        // R4: first arrival makes no entry, also after re-arm
        ctl_arm = 1'b0;
        clear_all();
        cfg_shift = '0;
        ctl_arm = 1'b1;
        send(1);
        drain();
        hist_sum(s);
        chk("R4 first no entry", 32'(s), 0);
        chk("R4 pkt_count", pkt_count, 1);
        ctl_arm = 1'b0;
        @(negedge clk);
        ctl_arm = 1'b1;
        repeat (4) @(negedge clk);
        send(2);
        drain();
        hist_sum(s);
        chk("R4 rearm no entry", 32'(s), 0);
        chk("R4 pkt_count rearm", pkt_count, 2);

        // R5: back-to-back same bin, and two-apart same bin
        ctl_arm = 1'b0;
        clear_all();
        ctl_arm = 1'b1;
        for (int k = 0; k < 6; k++) send(100 + k);
        drain();
        rd(2'd0, 1, v);
        chk("R5 burst bin1", v, 5);
        for (int k = 0; k < 3; k++) begin
            send(200 + k);
            @(negedge clk);
        end
        drain();
        rd(2'd0, 2, v);
        chk("R5 spaced bin2", v, 2);

        // R6: saturation
        ctl_arm = 1'b0;
        clear_all();
        ctl_arm = 1'b1;
        for (int k = 0; k < 40; k++) send(k);
        drain();
        rd(2'd0, 1, v);
        chk("R6 saturated bin", v, 31);

        // R7: log contents
        ctl_arm = 1'b0;
        clear_all();
        ctl_arm = 1'b1;
        send(500);
        repeat (3) @(negedge clk);
        send(501);
        repeat (8) @(negedge clk);
        send(502);
        drain();
        chk("R7 log_count", 32'(log_count), 3);
        rd(2'd2, 0, v);
        chk("R7 seq0", v, 500);
        rd(2'd2, 2, v);
        chk("R7 seq2", v, 502);
        rd(2'd1, 0, t0);
        rd(2'd1, 1, t1);
        chk("R7 ts delta 1", t1 - t0, 4);
        rd(2'd1, 2, t0);
        chk("R7 ts delta 2", t0 - t1, 9);

        // R8: log full, counting continues
        ctl_arm = 1'b0;
        clear_all();
        ctl_arm = 1'b1;
        for (int k = 0; k < 20; k++) begin
            send(700 + k);
            repeat (2) @(negedge clk);
        end
        drain();
        chk("R8 log_count", 32'(log_count), LD);
        chk("R8 log_full", 32'(log_full), 1);
        chk("R8 pkt_count", pkt_count, 20);
        rd(2'd0, 3, v);
        chk("R8 hist continues", v, 19);
        rd(2'd2, 15, v);
        chk("R8 last entry", v, 715);

        // R9: clear while arrivals continue
        ctl_clr = 1'b1;
        pkt_valid = 1'b1;
        @(negedge clk);
        ctl_clr = 1'b0;
        for (int k = 0; k < 5; k++) @(negedge clk);
        pkt_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R9 pkt_count", pkt_count, 0);
        chk("R9 log_count", 32'(log_count), 0);
        chk("R9 log_full", 32'(log_full), 0);
        hist_sum(s);
        chk("R9 hist zero", 32'(s), 0);

        // R10: disarmed arrivals ignored
        ctl_arm = 1'b0;
        for (int k = 0; k < 3; k++) send(900 + k);
        drain();
        chk("R10 pkt_count", pkt_count, 0);
        chk("R10 log_count", 32'(log_count), 0);

        // R11: reserved selector reads zero
        rd(2'd3, 0, v);
        chk("R11 reserved sel", v, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule